// File: doc/BRIEF.md
# Multi-channel ADC window alarm monitor

The block watches a stream of 12-bit conversion results. Each result carries a channel id, and the block keeps one alarm flag for each channel. There are eight channel ids, arranged as follows:

- Channels 0 to 2 have limits set by the user.
- Channels 3 to 6 are self-diagnostic inputs with fixed limit pairs.
- Channel 7 is a diagnostic input whose window follows an expected-code input.

A result that falls outside its channel's window counts as a failure. The block raises an alarm only after a programmable number of failures in a row. Failures on the high side and the low side add to the same count. Once an alarm is raised, it stays set until a result lands inside a window narrowed by a shared hysteresis value.

The block sits behind the ADC result path. The configuration fields and the expected code come straight from the register block and are applied without any buffering.

Top module: `adc_win_mon`

## Requirements
- R1: A result fails when it is strictly less than the channel's low limit or strictly greater than its high limit. A result equal to a limit passes.
- R2: The alarm for a channel sets on the result that brings its run of consecutive failures to `flt_cnt_i`. A `flt_cnt_i` of 0 behaves as 1. Each channel keeps its own counter, which saturates at the threshold.
- R3: High-side and low-side failures add to the same counter, even when they alternate. While the alarm is clear, any result inside the window resets that channel's count to zero.
- R4: A set alarm clears on the first result that is at least (low + `hyst_i`) and at most (high − `hyst_i`). Both values are clamped to the range 0x000..0xFFF. Clearing the alarm also zeroes the channel's count.
- R5: Programmable channel k (k = 0..2) takes its 8-bit fields from `prog_lo_i[8k+7:8k]` and `prog_hi_i[8k+7:8k]`. The 12-bit limits are {lo field, 4'h0} and {hi field, 4'hF}.
- R6: A programmable channel is disabled when its lo field is 0x00 and its hi field is 0xFF. A disabled channel never sets its alarm. A valid result on a disabled channel clears that channel's alarm.
- R7: Channels 3, 4, 5 and 6 use these fixed (low, high) limits: (0x6D0, 0x92F), (0x310, 0xD3F), (0x9C0, 0xD3F) and (0x690, 0x8CF).
- R8: Channel 7 uses `exp_code_i` − 0x040 as its low limit and `exp_code_i` + 0x040 as its high limit. Both are clamped to 0x000..0xFFF, so they never wrap.
- R9: Only a result with `res_valid_i` high is evaluated, and only by the channel whose id matches. Ids 8..15 are ignored. Channels that are not addressed keep their alarm state.
- R10: An alarm output changes on the clock edge that samples the valid result. The active-low asynchronous reset clears all alarms and counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result valid strobe |
| res_ch_i | input | 4 | Channel id of the result |
| res_val_i | input | 12 | Conversion value |
| prog_lo_i | input | 24 | Upper 8 bits of the low limit for channels 0..2 |
| prog_hi_i | input | 24 | Upper 8 bits of the high limit for channels 0..2 |
| flt_cnt_i | input | 4 | Consecutive failures needed to set an alarm |
| hyst_i | input | 8 | Hysteresis applied when releasing an alarm |
| exp_code_i | input | 12 | Expected code for the tracking channel |
| alarm_o | output | 8 | Alarm flag per channel |

## Verification
In a single cycle, one result can be judged against both the failure window and the narrower release window. The bench provokes this in two ways. It sends values that sit between a limit and that limit adjusted by the hysteresis, which leaves a set alarm held while a clear alarm's count is reset. It then sends the exact release boundary value, which clears the alarm and must also zero the count. Every value sent is compared against the alarm vector after the sampling edge, so a count that survives the release shows up as an early alarm on the following failures.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;
  localparam int unsigned VAL_W = 12;
  typedef logic [VAL_W-1:0] code_t;

  typedef enum logic [1:0] {
    LIM_PROG  = 2'd0,
    LIM_FIXED = 2'd1,
    LIM_TRACK = 2'd2
  } lim_kind_e;

  function automatic code_t fix_lo(input int unsigned idx);
    case (idx)
      0:       return 12'h6D0;
      1:       return 12'h310;
      2:       return 12'h9C0;
      default: return 12'h690;
    endcase
  endfunction

  function automatic code_t fix_hi(input int unsigned idx);
    case (idx)
      0:       return 12'h92F;
      1:       return 12'hD3F;
      2:       return 12'hD3F;
      default: return 12'h8CF;
    endcase
  endfunction
endpackage

// File: rtl/adc_win_limits.sv
module adc_win_limits
  import adc_win_pkg::*;
#(
  parameter lim_kind_e   KIND    = LIM_PROG,
  parameter int unsigned FIX_IDX = 0,
  parameter int unsigned FLD_W   = 8,
  parameter int unsigned TRK_OFS = 12'h040
) (
  input  logic [FLD_W-1:0] lo_fld_i,
  input  logic [FLD_W-1:0] hi_fld_i,
  input  code_t            exp_i,
  output code_t            lo_o,
  output code_t            hi_o,
  output logic             dis_o
);
  localparam int unsigned PAD_W = VAL_W - FLD_W;
  localparam code_t OFS = code_t'(TRK_OFS);
  localparam code_t MAXC = '1;

  generate
    if (KIND == LIM_PROG) begin : g_prog
      assign lo_o  = {lo_fld_i, {PAD_W{1'b0}}};
      assign hi_o  = {hi_fld_i, {PAD_W{1'b1}}};
      assign dis_o = (lo_fld_i == '0) && (hi_fld_i == '1);
    end else if (KIND == LIM_FIXED) begin : g_fixed
      assign lo_o  = fix_lo(FIX_IDX);
      assign hi_o  = fix_hi(FIX_IDX);
      assign dis_o = 1'b0;
    end else begin : g_track
      // clamp both edges so the window never wraps
      assign lo_o  = (exp_i >= OFS) ? exp_i - OFS : '0;
      assign hi_o  = (exp_i > MAXC - OFS) ? MAXC : exp_i + OFS;
      assign dis_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/adc_win_chan.sv
module adc_win_chan
  import adc_win_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned HYST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  code_t             val_i,
  input  code_t             lo_i,
  input  code_t             hi_i,
  input  logic              dis_i,
  input  logic [CNT_W-1:0]  flt_cnt_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic              alarm_o
);
  localparam code_t MAXC = '1;

  logic [CNT_W-1:0] cnt_q, cnt_inc, eff_cnt;
  logic             alarm_q;
  logic             fail, in_rel;
  code_t            hyst_c, rel_lo, rel_hi;

  assign eff_cnt = (flt_cnt_i == '0) ? CNT_W'(1) : flt_cnt_i;
  assign hyst_c  = code_t'(hyst_i);
  assign fail    = !dis_i && ((val_i < lo_i) || (val_i > hi_i));
  assign rel_lo  = (lo_i > MAXC - hyst_c) ? MAXC : lo_i + hyst_c;
  assign rel_hi  = (hi_i < hyst_c) ? '0 : hi_i - hyst_c;
  assign in_rel  = (val_i >= rel_lo) && (val_i <= rel_hi);
  assign cnt_inc = (cnt_q >= eff_cnt) ? eff_cnt : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else if (hit_i) begin
      if (dis_i) begin
        cnt_q   <= '0;
        alarm_q <= 1'b0;
      end else if (alarm_q) begin
        if (in_rel) begin
          cnt_q   <= '0;
          alarm_q <= 1'b0;
        end
      end else if (fail) begin
        cnt_q <= cnt_inc;
        if (cnt_inc >= eff_cnt) alarm_q <= 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign alarm_o = alarm_q;

  // R9
  no_idle_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(alarm_o));
  // R1
  rise_on_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(hit_i && ((val_i < lo_i) || (val_i > hi_i))));
  // R6
  dis_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && dis_i) |=> !alarm_o);
  // R4
  release_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_o) |-> $past(hit_i && (dis_i || val_i >= lo_i)));
  // R2
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= eff_cnt || $changed(flt_cnt_i) || $past(flt_cnt_i) != flt_cnt_i);
endmodule

// File: rtl/adc_win_mon.sv
module adc_win_mon
  import adc_win_pkg::*;
#(
  parameter int unsigned NUM_PROG = 3,
  parameter int unsigned NUM_FIX  = 4,
  parameter int unsigned CH_W     = 4,
  parameter int unsigned FLD_W    = 8,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned HYST_W   = 8,
  parameter int unsigned TRK_OFS  = 12'h040,
  localparam int unsigned NUM_CH  = NUM_PROG + NUM_FIX + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      res_valid_i,
  input  logic [CH_W-1:0]           res_ch_i,
  input  logic [VAL_W-1:0]          res_val_i,
  input  logic [NUM_PROG*FLD_W-1:0] prog_lo_i,
  input  logic [NUM_PROG*FLD_W-1:0] prog_hi_i,
  input  logic [CNT_W-1:0]          flt_cnt_i,
  input  logic [HYST_W-1:0]         hyst_i,
  input  logic [VAL_W-1:0]          exp_code_i,
  output logic [NUM_CH-1:0]         alarm_o
);
  logic [NUM_CH-1:0] hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    code_t             lo, hi;
    logic              dis;
    logic [FLD_W-1:0]  lo_fld, hi_fld;

    if (c < NUM_PROG) begin : g_fld
      assign lo_fld = prog_lo_i[c*FLD_W +: FLD_W];
      assign hi_fld = prog_hi_i[c*FLD_W +: FLD_W];
    end else begin : g_nofld
      assign lo_fld = '0;
      assign hi_fld = '0;
    end

    assign hit[c] = res_valid_i && (res_ch_i == CH_W'(c));

    adc_win_limits #(
      .KIND   (c < NUM_PROG ? LIM_PROG :
               (c < NUM_PROG + NUM_FIX ? LIM_FIXED : LIM_TRACK)),
      .FIX_IDX(c < NUM_PROG ? 0 : c - NUM_PROG),
      .FLD_W  (FLD_W),
      .TRK_OFS(TRK_OFS)
    ) i_lim (
      .lo_fld_i(lo_fld),
      .hi_fld_i(hi_fld),
      .exp_i   (exp_code_i),
      .lo_o    (lo),
      .hi_o    (hi),
      .dis_o   (dis)
    );

    adc_win_chan #(
      .CNT_W (CNT_W),
      .HYST_W(HYST_W)
    ) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit[c]),
      .val_i    (res_val_i),
      .lo_i     (lo),
      .hi_i     (hi),
      .dis_i    (dis),
      .flt_cnt_i(flt_cnt_i),
      .hyst_i   (hyst_i),
      .alarm_o  (alarm_o[c])
    );
  end

  // R9
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  // R10
  reset_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> alarm_o == '0);
endmodule

// File: tb/test_adc_win_mon.sv
module test_adc_win_mon;
  localparam time CLK_T = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [3:0]  ch = '0;
  logic [11:0] val = '0;
  logic [23:0] plo = '0;
  logic [23:0] phi = '1;
  logic [3:0]  flt = 4'd3;
  logic [7:0]  hyst = 8'h20;
  logic [11:0] expc = 12'h800;
  logic [7:0]  alarm;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  adc_win_mon i_adc_win_mon (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(vld), .res_ch_i(ch),
    .res_val_i(val), .prog_lo_i(plo), .prog_hi_i(phi), .flt_cnt_i(flt),
    .hyst_i(hyst), .exp_code_i(expc), .alarm_o(alarm)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: alarm got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [11:0] v);
    @(negedge clk); vld = 1'b1; ch = c; val = v;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic set_prog(input int c, input logic [7:0] lo, input logic [7:0] hi);
    plo[c*8 +: 8] = lo; phi[c*8 +: 8] = hi;
  endtask

  task automatic t_reset;
    chk("R10 reset", alarm, 8'h00);
  endtask

  task automatic t_strict;
    set_prog(0, 8'h40, 8'h80);
    flt = 3;
    repeat (3) send(0, 12'h400);
    repeat (3) send(0, 12'h80F);
    chk("R1 equal limits pass", alarm, 8'h00);
    send(0, 12'h3FF); send(0, 12'h3FF);
    chk("R2 two fails below count", alarm, 8'h00);
    send(0, 12'h3FF);
    chk("R1 R5 below low limit trips", alarm, 8'h01);
    send(0, 12'h600);
    chk("R4 clear mid window", alarm, 8'h00);
  endtask

  task automatic t_count_hyst_high;
    send(0, 12'h810); send(0, 12'h810);
    chk("R2 not yet", alarm, 8'h00);
    send(0, 12'h810);
    chk("R2 third fail sets", alarm, 8'h01);
    send(0, 12'h7F0);
    chk("R4 high hyst holds", alarm, 8'h01);
    send(0, 12'h7EF);
    chk("R4 high hyst release", alarm, 8'h00);
    send(0, 12'h810); send(0, 12'h810);
    chk("R4 release zeroes count", alarm, 8'h00);
    send(0, 12'h600);
  endtask

  task automatic t_alternate;
    set_prog(1, 8'h40, 8'h80);
    send(1, 12'h810); send(1, 12'h3FF);
    chk("R3 alternating two", alarm, 8'h00);
    send(1, 12'h810);
    chk("R3 alternating sets", alarm, 8'h02);
    send(1, 12'h41F);
    chk("R4 low hyst holds", alarm, 8'h02);
    send(1, 12'h420);
    chk("R4 low hyst release", alarm, 8'h00);
  endtask

  task automatic t_count_reset;
    set_prog(2, 8'h40, 8'h80);
    send(2, 12'h900); send(2, 12'h900); send(2, 12'h410);
    send(2, 12'h900); send(2, 12'h900);
    chk("R3 in-window clears count", alarm, 8'h00);
    send(2, 12'h900);
    chk("R3 count restarts", alarm, 8'h04);
  endtask

  task automatic t_disabled;
    set_prog(2, 8'h00, 8'hFF);
    send(2, 12'h000);
    chk("R6 disable clears alarm", alarm, 8'h00);
    flt = 1;
    send(2, 12'hFFF); send(2, 12'h000);
    chk("R6 disabled never sets", alarm, 8'h00);
  endtask

  task automatic t_flt_zero;
    flt = 0;
    send(0, 12'h900);
    chk("R2 zero acts as one", alarm, 8'h01);
    send(0, 12'h600);
    flt = 1;
  endtask

  task automatic t_fixed;
    send(3, 12'h6D0); chk("R7 sd0 low edge", alarm, 8'h00);
    send(3, 12'h6CF); chk("R7 sd0 low", alarm, 8'h08);
    send(3, 12'h6E0); chk("R4 sd0 holds", alarm, 8'h08);
    send(3, 12'h800);
    send(3, 12'h930); chk("R7 sd0 high", alarm, 8'h08);
    send(3, 12'h800);
    send(4, 12'hD3F); chk("R7 sd1 high edge", alarm, 8'h00);
    send(4, 12'hD40); chk("R7 sd1 high", alarm, 8'h10);
    send(4, 12'h30F); chk("R7 sd1 low", alarm, 8'h10);
    send(4, 12'h800);
    send(5, 12'h9BF); chk("R7 sd2 low", alarm, 8'h20);
    send(5, 12'hB00);
    send(6, 12'h8D0); chk("R7 sd3 high", alarm, 8'h40);
    send(6, 12'h68F); send(6, 12'h7A0);
    chk("R7 all cleared", alarm, 8'h00);
  endtask

  task automatic t_track;
    expc = 12'h800;
    send(7, 12'h7C0); send(7, 12'h840);
    chk("R8 window edges pass", alarm, 8'h00);
    send(7, 12'h7BF); chk("R8 below window", alarm, 8'h80);
    send(7, 12'h800);
    send(7, 12'h841); chk("R8 above window", alarm, 8'h80);
    expc = 12'hFE0;
    send(7, 12'hFD0); chk("R8 R4 release near top", alarm, 8'h00);
    send(7, 12'hFFF); chk("R8 high clamp", alarm, 8'h00);
    expc = 12'h010;
    send(7, 12'h000); chk("R8 low clamp", alarm, 8'h00);
    send(7, 12'h051); chk("R8 low region high side", alarm, 8'h80);
    send(7, 12'h030); chk("R8 clear", alarm, 8'h00);
  endtask

  task automatic t_ignore;
    @(negedge clk); vld = 1'b0; ch = 0; val = 12'h900;
    @(negedge clk);
    chk("R9 valid low ignored", alarm, 8'h00);
    for (int i = 8; i < 16; i++) send(4'(i), 12'hFFF);
    chk("R9 out of range ids ignored", alarm, 8'h00);
    send(1, 12'h900);
    chk("R9 other channels untouched", alarm, 8'h02);
    send(0, 12'h900);
    chk("R9 two alarms independent", alarm, 8'h03);
  endtask

  task automatic t_mid_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 async reset clears", alarm, 8'h00);
    rst_n = 1'b1;
    send(0, 12'h900);
    chk("R10 single cycle latency", alarm, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strict();
    t_count_hyst_high();
    t_alternate();
    t_count_reset();
    t_disabled();
    t_flt_zero();
    t_fixed();
    t_track();
    t_ignore();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule